// File: doc/BRIEF.md
# GPIO Port Register Group

This block is one 32-pin general-purpose I/O port group behind a simple register bus. It holds a direction register, an output data register and per-pin configuration words. It also presents a sampled view of the pad levels. Three write-only alias addresses change selected output bits in a single access: one sets them, one clears them and one inverts them. Software therefore never needs a read-modify-write to change one pin.

Each pin has an input-buffer enable, a pull selection and a power-save bit. Power-save overrides every other setting of that pin. Pad levels pass through a two-flop synchronizer before they reach the input view. A pin whose input buffer is off returns its own output data bit there, so an output-only pin reads back the value it last drove. Toward the pad the block drives an output level, an output enable and two pull requests. Logical GPIO number g belongs to the group holding it and sits at bit (g mod 32).

The register bus is a plain strobe interface with no back-pressure. A request is accepted in every cycle where `bus_en` is high, and only one request can be made per cycle. Read data returns on `bus_rdata` with `bus_rvalid` high for one cycle, on the clock edge after the edge that accepts the read. Word offsets: direction 0x00, output data 0x04, clear alias 0x08, set alias 0x0C, toggle alias 0x10, input view 0x14, and the configuration of pin p at 0x40 + 4·p. Address bits [1:0] are ignored.

Top module: `gpio_port_group`

## Requirements
- R1: After reset, direction and output data are all 0, `pad_oe` is 0, `pad_pu` is all ones, `pad_pd` is 0, and every configuration word reads 0x3. The configuration word encoding is: bit 0 is input-buffer enable, bits [2:1] are the pull (00 none, 01 up, 10 down, 11 none), and bit 3 is power-save.
- R2: A write to 0x00 or 0x04 replaces the direction or output data register, which reads back unchanged. `pad_o` equals the output data and `pad_oe` equals the direction for pins without power-save.
- R3: A write to the set alias (0x0C) sets to 1 every output bit whose data bit is 1 and leaves the other output bits unchanged.
- R4: A write to the clear alias (0x08) clears every output bit whose data bit is 1 and leaves the other output bits unchanged.
- R5: A write to the toggle alias (0x10) inverts every output bit whose data bit is 1.
- R6: The three alias addresses and unmapped addresses read as zero. Writes to the input view (0x14) or to unmapped addresses change no register.
- R7: A pad level change applied before clock edge k is returned by an input-view read accepted at edge k+2 or later. A read accepted at edge k+1 still returns the old level.
- R8: For a pin whose input buffer is disabled, the input view returns that pin's output data bit instead of the pad level.
- R9: `pad_pu` or `pad_pd` is asserted for a pin only when its pull selects up or down, its direction is input and power-save is off.
- R10: With power-save set, a pin has `pad_oe`, `pad_pu` and `pad_pd` at 0, and its input view returns its output data bit, whatever its other settings are.
- R11: `bus_rvalid` is high exactly one cycle after each accepted read and low after writes and idle cycles.
- R12: A set-alias write of (mask AND level) followed by a clear-alias write of (mask AND NOT level) leaves output data equal to (old AND NOT mask) OR (level AND mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid pulse |
| pad_i | input | PINS | Pad levels (asynchronous) |
| pad_o | output | PINS | Output level to pads |
| pad_oe | output | PINS | Output driver enable per pin |
| pad_pu | output | PINS | Pull-up request per pin |
| pad_pd | output | PINS | Pull-down request per pin |

## Verification
Register writes take effect at the edge that accepts them. The pad outputs and any later read reflect the new value from that edge onward. Read data appears on the edge after the read is accepted. A pad change needs two synchronizer edges, so only a read accepted at the third edge after the change returns the new level. The bench drives every request at a falling edge, lets exactly one rising edge accept it, and samples results at the following falling edge. It deliberately checks the second-edge read for the old input level and the third-edge read for the new one.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_UP   = 2'b01,
    PULL_DOWN = 2'b10,
    PULL_ALT  = 2'b11
  } pull_sel_e;

  // bit 3 power-save, bits 2:1 pull, bit 0 input-buffer enable
  typedef struct packed {
    logic      psave;
    pull_sel_e pull;
    logic      inen;
  } pin_cfg_t;

  localparam int unsigned CFG_W = $bits(pin_cfg_t);
  localparam pin_cfg_t CFG_RESET = '{psave: 1'b0, pull: PULL_UP, inen: 1'b1};

  // word indices (byte address / 4)
  localparam int unsigned W_DIR      = 0;
  localparam int unsigned W_OUT      = 1;
  localparam int unsigned W_CLR      = 2;
  localparam int unsigned W_SET      = 3;
  localparam int unsigned W_TGL      = 4;
  localparam int unsigned W_IN       = 5;
  localparam int unsigned W_CFG_BASE = 16;

endpackage

// File: rtl/gpio_port_outreg.sv
module gpio_port_outreg #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_dir,
  input  logic            wr_out,
  input  logic            wr_clr,
  input  logic            wr_set,
  input  logic            wr_tgl,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] out_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_out)      out_q <= wdata;
      else if (wr_set) out_q <= out_q | wdata;
      else if (wr_clr) out_q <= out_q & ~wdata;
      else if (wr_tgl) out_q <= out_q ^ wdata;
    end
  end

  p_plain_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> out_q == $past(wdata));

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_q & $past(wdata)) == $past(wdata)) &&
               (((out_q ^ $past(out_q)) & ~$past(wdata)) == '0));

  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((out_q & $past(wdata)) == '0) &&
               (((out_q ^ $past(out_q)) & ~$past(wdata)) == '0));

  p_tgl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tgl |=> (out_q ^ $past(out_q)) == $past(wdata));

endmodule

// File: rtl/gpio_port_cfgbank.sv
module gpio_port_cfgbank
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS  = 32,
  parameter int unsigned IDX_W = $clog2(PINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CFG_W-1:0] wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output pin_cfg_t         rd_cfg,
  output logic [PINS-1:0]  inen_vec,
  output logic [PINS-1:0]  psave_vec,
  output logic [PINS-1:0]  pu_sel_vec,
  output logic [PINS-1:0]  pd_sel_vec
);

  logic [PINS-1:0][CFG_W-1:0] cfg_flat;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    pin_cfg_t cfg_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cfg_r <= CFG_RESET;
      else if (wr_en && wr_idx == IDX_W'(i))     cfg_r <= pin_cfg_t'(wdata);
    end
    assign cfg_flat[i]   = cfg_r;
    assign inen_vec[i]   = cfg_r.inen;
    assign psave_vec[i]  = cfg_r.psave;
    assign pu_sel_vec[i] = (cfg_r.pull == PULL_UP);
    assign pd_sel_vec[i] = (cfg_r.pull == PULL_DOWN);
  end

  assign rd_cfg = pin_cfg_t'(cfg_flat[rd_idx]);

  p_pull_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_sel_vec & pd_sel_vec) == '0);

endmodule

// File: rtl/gpio_port_inpath.sv
module gpio_port_inpath #(
  parameter int unsigned PINS        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pad_i,
  input  logic [PINS-1:0] sample_en,
  input  logic [PINS-1:0] out_q,
  output logic [PINS-1:0] in_view
);

  logic [SYNC_STAGES-1:0][PINS-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= pad_i;
      for (int k = 1; k < SYNC_STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  // disabled input buffer returns the driven output level
  assign in_view = (stg[SYNC_STAGES-1] & sample_en) | (out_q & ~sample_en);

  if (SYNC_STAGES == 2) begin : g_chk
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              warm_q <= '0;
      else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
    p_sync_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd2) |-> stg[1] == $past(pad_i, 2));
  end

endmodule

// File: rtl/gpio_port_group.sv
module gpio_port_group
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  output logic              bus_rvalid,
  input  logic [PINS-1:0]   pad_i,
  output logic [PINS-1:0]   pad_o,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_pu,
  output logic [PINS-1:0]   pad_pd
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned IDX_W  = $clog2(PINS);
  localparam logic [WORD_W-1:0] WD_DIR  = WORD_W'(W_DIR);
  localparam logic [WORD_W-1:0] WD_OUT  = WORD_W'(W_OUT);
  localparam logic [WORD_W-1:0] WD_CLR  = WORD_W'(W_CLR);
  localparam logic [WORD_W-1:0] WD_SET  = WORD_W'(W_SET);
  localparam logic [WORD_W-1:0] WD_TGL  = WORD_W'(W_TGL);
  localparam logic [WORD_W-1:0] WD_IN   = WORD_W'(W_IN);
  localparam logic [WORD_W-1:0] WD_CFG0 = WORD_W'(W_CFG_BASE);
  localparam logic [WORD_W-1:0] WD_CFGE = WORD_W'(W_CFG_BASE + PINS);

  logic [WORD_W-1:0] word;
  logic [1:0]        unused_addr_lsb;
  logic              wr, rd;
  logic              hit_dir, hit_out, hit_clr, hit_set, hit_tgl, hit_in, hit_cfg;
  logic [WORD_W-1:0] cfg_off;
  logic [IDX_W-1:0]  cfg_idx;

  assign word            = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = bus_addr[1:0];
  assign wr              = bus_en & bus_we;
  assign rd              = bus_en & ~bus_we;
  assign hit_dir = (word == WD_DIR);
  assign hit_out = (word == WD_OUT);
  assign hit_clr = (word == WD_CLR);
  assign hit_set = (word == WD_SET);
  assign hit_tgl = (word == WD_TGL);
  assign hit_in  = (word == WD_IN);
  assign hit_cfg = (word >= WD_CFG0) && (word < WD_CFGE);
  assign cfg_off = word - WD_CFG0;
  assign cfg_idx = cfg_off[IDX_W-1:0];

  logic [PINS-1:0] dir_q, out_q, in_view;
  logic [PINS-1:0] inen_vec, psave_vec, pu_sel_vec, pd_sel_vec, inen_eff;
  pin_cfg_t        rd_cfg;

  gpio_port_outreg #(.PINS(PINS)) u_outreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_dir (wr & hit_dir),
    .wr_out (wr & hit_out),
    .wr_clr (wr & hit_clr),
    .wr_set (wr & hit_set),
    .wr_tgl (wr & hit_tgl),
    .wdata  (bus_wdata),
    .dir_q  (dir_q),
    .out_q  (out_q)
  );

  gpio_port_cfgbank #(.PINS(PINS), .IDX_W(IDX_W)) u_cfgbank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr & hit_cfg),
    .wr_idx     (cfg_idx),
    .wdata      (bus_wdata[CFG_W-1:0]),
    .rd_idx     (cfg_idx),
    .rd_cfg     (rd_cfg),
    .inen_vec   (inen_vec),
    .psave_vec  (psave_vec),
    .pu_sel_vec (pu_sel_vec),
    .pd_sel_vec (pd_sel_vec)
  );

  assign inen_eff = inen_vec & ~psave_vec;

  gpio_port_inpath #(.PINS(PINS), .SYNC_STAGES(2)) u_inpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_i     (pad_i),
    .sample_en (inen_eff),
    .out_q     (out_q),
    .in_view   (in_view)
  );

  // pad side: power-save wins, pulls only while not driving
  assign pad_o  = out_q;
  assign pad_oe = dir_q & ~psave_vec;
  assign pad_pu = pu_sel_vec & ~dir_q & ~psave_vec;
  assign pad_pd = pd_sel_vec & ~dir_q & ~psave_vec;

  logic [PINS-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_cfg)      rd_mux = {{(PINS-CFG_W){1'b0}}, rd_cfg};
    else if (hit_dir) rd_mux = dir_q;
    else if (hit_out) rd_mux = out_q;
    else if (hit_in)  rd_mux = in_view;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);

  p_rvalid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !bus_rvalid);

  p_alias_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd && (hit_clr || hit_set || hit_tgl) |=> bus_rdata == '0);

  p_psave_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_pu | pad_pd) & psave_vec) == '0);

endmodule

// File: tb/gpio_port_group_tb_top.sv
module gpio_port_group_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] pad_i = '0;
  logic [31:0] pad_o, pad_oe, pad_pu, pad_pd;

  int n_checks = 0;
  int n_err    = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_port_group #(.PINS(32), .ADDR_W(8)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .bus_en (bus_en), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid),
    .pad_i (pad_i), .pad_o (pad_o), .pad_oe (pad_oe),
    .pad_pu (pad_pu), .pad_pd (pad_pd)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] data;  // write data, or expected read data
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 32'h0000FFFF, 8'd2},   // R2 direction
    '{1'b0, 8'h00, 32'h0000FFFF, 8'd2},
    '{1'b1, 8'h04, 32'h12345678, 8'd2},   // R2 output data
    '{1'b0, 8'h04, 32'h12345678, 8'd2},
    '{1'b1, 8'h0C, 32'hF0000001, 8'd3},   // R3 set alias
    '{1'b0, 8'h04, 32'hF2345679, 8'd3},
    '{1'b1, 8'h08, 32'h0000F00F, 8'd4},   // R4 clear alias
    '{1'b0, 8'h04, 32'hF2340670, 8'd4},
    '{1'b1, 8'h10, 32'hFFFF0000, 8'd5},   // R5 toggle alias
    '{1'b0, 8'h04, 32'h0DCB0670, 8'd5},
    '{1'b0, 8'h08, 32'h00000000, 8'd6},   // R6 aliases read zero
    '{1'b0, 8'h0C, 32'h00000000, 8'd6},
    '{1'b0, 8'h10, 32'h00000000, 8'd6},
    '{1'b1, 8'h14, 32'hFFFFFFFF, 8'd6},   // R6 write to input view ignored
    '{1'b0, 8'h14, 32'h00000000, 8'd6},
    '{1'b1, 8'h20, 32'hFFFFFFFF, 8'd6},   // R6 unmapped
    '{1'b0, 8'h20, 32'h00000000, 8'd6},
    '{1'b0, 8'h04, 32'h0DCB0670, 8'd6},
    '{1'b1, 8'h0C, 32'h000000A5, 8'd12},  // R12 masked level write
    '{1'b1, 8'h08, 32'h0000005A, 8'd12},
    '{1'b0, 8'h04, 32'h0DCB06A5, 8'd12}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_o", pad_o, 32'h0);
    check("R1 pad_pu", pad_pu, 32'hFFFFFFFF);
    check("R1 pad_pd", pad_pd, 32'h0);
    bus_read(8'h00, rd); check("R1 dir", rd, 32'h0);
    bus_read(8'h40, rd); check("R1 cfg pin0", rd, 32'h3);
    bus_read(8'hBC, rd); check("R1 cfg pin31", rd, 32'h3);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) bus_write(VEC[i].addr, VEC[i].data);
      else begin
        bus_read(VEC[i].addr, rd);
        check($sformatf("R%0d vec%0d", VEC[i].rq, i), rd, VEC[i].data);
      end
    end

    // R7 synchronizer latency
    pad_i = 32'hA5A500FF;
    bus_read(8'h14, rd);
    bus_read(8'h14, rd); check("R7 second edge old", rd, 32'h0);
    bus_read(8'h14, rd); check("R7 third edge new", rd, 32'hA5A500FF);

    // R8 input buffer off on pin 3: reads its output bit (0)
    bus_write(8'h4C, 32'h2);
    bus_read(8'h14, rd); check("R8 readback low", rd, 32'hA5A500F7);
    bus_write(8'h10, 32'h8);
    bus_read(8'h14, rd); check("R8 readback high", rd, 32'hA5A500FF);
    check("R2 pad_o", pad_o, 32'h0DCB06AD);
    check("R2 pad_oe", pad_oe, 32'h0000FFFF);

    // R9 pulls follow selection and direction
    check("R9 pu default", pad_pu, 32'hFFFF0000);
    bus_write(8'h90, 32'h5);
    check("R9 pd pin20", pad_pd, 32'h00100000);
    check("R9 pu pin20", pad_pu, 32'hFFEF0000);
    bus_write(8'h94, 32'h1);
    check("R9 pu none pin21", pad_pu, 32'hFFCF0000);

    // R10 power-save overrides
    bus_write(8'h40, 32'hB);
    bus_write(8'h98, 32'hB);
    check("R10 pad_oe", pad_oe, 32'h0000FFFE);
    check("R10 pad_pu", pad_pu, 32'hFF8F0000);
    bus_read(8'h14, rd); check("R10 input view", rd, 32'hA5E500FF);
    bus_read(8'h98, rd); check("R10 cfg stored", rd, 32'hB);

    // R11 read-valid pulse
    bus_write(8'h04, 32'h0DCB06AD);
    check("R11 no valid after write", {31'b0, bus_rvalid}, 32'h0);
    bus_read(8'h04, rd);
    check("R11 valid after read", {31'b0, bus_rvalid}, 32'h1);
    @(negedge clk);
    check("R11 valid drops", {31'b0, bus_rvalid}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule